// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the main control decoder of a single-cycle processor. It is purely combinational. Each cycle it takes the 6-bit opcode of the instruction being executed, plus the 6-bit function field where that field matters. From these it drives every select and enable that the datapath needs to finish the instruction within that cycle.

The base set covers register-register arithmetic, word load and store, branch-if-equal and the absolute jump. The decoder also handles three extensions:

- A jump that saves the return address in register 31.
- A load whose address is the sum of two registers.
- A jump whose target is read from data memory.

To support these, the destination-register select, the write-back select and the next-PC select are each two bits wide. The ALU and the datapath multiplexers sit outside this block.

Any opcode the decoder does not recognise produces all-zero controls. As a result no register or memory is written and the program counter simply advances by four. Every control that has no meaning for a given instruction is driven to 0.

Top module: `main_ctrl_dec`

## Requirements
- R1: Opcode 0 with any function code other than 1 gives dst_sel=01 (rd), alu_b_imm=0, wb_sel=00 (ALU), rf_we=1, dmem_re=0, dmem_we=0, br_eq=0, alu_mode=10 (function-decoded), pc_jsel=00.
- R2: Opcode 35 (word load) gives dst_sel=00 (rt), alu_b_imm=1, wb_sel=01 (memory), rf_we=1, dmem_re=1, alu_mode=00 (add), and 0 on every other output.
- R3: Opcode 43 (word store) gives alu_b_imm=1, dmem_we=1, alu_mode=00, and 0 on every other output, including rf_we.
- R4: Opcode 4 (branch if equal) gives br_eq=1, alu_mode=01 (subtract), alu_b_imm=0, and 0 on every other output.
- R5: Opcode 2 (jump) gives pc_jsel=01 (jump target), and 0 on every other output.
- R6: Opcode 3 (jump and save return) gives pc_jsel=01, rf_we=1, dst_sel=10 (register 31), wb_sel=10 (PC+4), and 0 on every other output.
- R7: Opcode 0 with function code 000001 (register-indexed load) gives dst_sel=01, alu_b_imm=0, wb_sel=01, rf_we=1, dmem_re=1, alu_mode=00, and 0 on every other output.
- R8: Opcode 63 (memory-indirect jump) gives alu_b_imm=1, dmem_re=1, pc_jsel=10 (memory data), and 0 on every other output.
- R9: For every nonzero opcode, the function field has no effect on any output.
- R10: Every opcode not named in R1 to R8 gives 0 on all outputs.
- R11: dmem_re and dmem_we are never both 1, and rf_we is never 1 together with dmem_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| dst_sel | output | 2 | Write register select: 00 rt, 01 rd, 10 register 31 |
| alu_b_imm | output | 1 | Second ALU operand is the extended immediate |
| wb_sel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| rf_we | output | 1 | Register file write enable |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| br_eq | output | 1 | Conditional branch on ALU zero |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function-decoded |
| pc_jsel | output | 2 | Next PC: 00 sequential/branch, 01 jump target, 10 memory data |

## Verification
The bench builds the decoder with its default 6-bit opcode and 6-bit function field widths. At these widths the whole input space is only 4096 combinations, so every one of them is applied and compared with a control word computed in the bench.

This sweep covers several things completely:
- Every unrecognised opcode.
- Every function code paired with each nonzero opcode, which is where insensitivity to the function field shows.
- The single function code that turns opcode 0 into the indexed load, against all 63 that leave it as arithmetic.

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec #(
  parameter int OPW = 6,
  parameter int FNW = 6
) (
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output logic [1:0]     dst_sel,
  output logic           alu_b_imm,
  output logic [1:0]     wb_sel,
  output logic           rf_we,
  output logic           dmem_re,
  output logic           dmem_we,
  output logic           br_eq,
  output logic [1:0]     alu_mode,
  output logic [1:0]     pc_jsel
);
  localparam logic [OPW-1:0] OP_REG  = OPW'(0);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(2);
  localparam logic [OPW-1:0] OP_JSV  = OPW'(3);
  localparam logic [OPW-1:0] OP_BEQ  = OPW'(4);
  localparam logic [OPW-1:0] OP_LDW  = OPW'(35);
  localparam logic [OPW-1:0] OP_STW  = OPW'(43);
  localparam logic [OPW-1:0] OP_IJMP = OPW'(63);
  localparam logic [FNW-1:0] FN_LDX  = FNW'(1);

  localparam logic [1:0] DST_RT = 2'b00, DST_RD = 2'b01, DST_R31 = 2'b10;
  localparam logic [1:0] WB_ALU = 2'b00, WB_MEM = 2'b01, WB_LINK = 2'b10;
  localparam logic [1:0] AM_ADD = 2'b00, AM_SUB = 2'b01, AM_FN = 2'b10;
  localparam logic [1:0] PJ_SEQ = 2'b00, PJ_TGT = 2'b01, PJ_MEM = 2'b10;

  logic is_ldx;
  assign is_ldx = (funct == FN_LDX);

  always_comb begin
    dst_sel   = DST_RT;
    alu_b_imm = 1'b0;
    wb_sel    = WB_ALU;
    rf_we     = 1'b0;
    dmem_re   = 1'b0;
    dmem_we   = 1'b0;
    br_eq     = 1'b0;
    alu_mode  = AM_ADD;
    pc_jsel   = PJ_SEQ;
    case (opcode)
      OP_REG: begin
        dst_sel = DST_RD;
        rf_we   = 1'b1;
        if (is_ldx) begin
          wb_sel   = WB_MEM;
          dmem_re  = 1'b1;
          alu_mode = AM_ADD;
        end else begin
          alu_mode = AM_FN;
        end
      end
      OP_LDW: begin
        alu_b_imm = 1'b1;
        wb_sel    = WB_MEM;
        rf_we     = 1'b1;
        dmem_re   = 1'b1;
      end
      OP_STW: begin
        alu_b_imm = 1'b1;
        dmem_we   = 1'b1;
      end
      OP_BEQ: begin
        br_eq    = 1'b1;
        alu_mode = AM_SUB;
      end
      OP_JMP: pc_jsel = PJ_TGT;
      OP_JSV: begin
        pc_jsel = PJ_TGT;
        rf_we   = 1'b1;
        dst_sel = DST_R31;
        wb_sel  = WB_LINK;
      end
      OP_IJMP: begin
        alu_b_imm = 1'b1;
        dmem_re   = 1'b1;
        pc_jsel   = PJ_MEM;
      end
      default: ;
    endcase
  end
endmodule

module main_ctrl_dec_chk #(
  parameter int OPW = 6,
  parameter int FNW = 6
) (
  input logic [OPW-1:0] opcode,
  input logic [FNW-1:0] funct,
  input logic [1:0]     dst_sel,
  input logic           alu_b_imm,
  input logic [1:0]     wb_sel,
  input logic           rf_we,
  input logic           dmem_re,
  input logic           dmem_we,
  input logic           br_eq,
  input logic [1:0]     alu_mode,
  input logic [1:0]     pc_jsel
);
  logic [12:0] word;
  assign word = {dst_sel, alu_b_imm, wb_sel, rf_we, dmem_re, dmem_we, br_eq, alu_mode, pc_jsel};

  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      if (opcode == OPW'(0) && funct != FNW'(1))
        assert_rtype_R1: assert (word == 13'b01_0_00_1_0_0_0_10_00);
      if (opcode == OPW'(35))
        assert_load_R2: assert (word == 13'b00_1_01_1_1_0_0_00_00);
      if (opcode == OPW'(43))
        assert_store_R3: assert (word == 13'b00_1_00_0_0_1_0_00_00);
      if (opcode == OPW'(4))
        assert_beq_R4: assert (word == 13'b00_0_00_0_0_0_1_01_00);
      if (opcode == OPW'(2))
        assert_jump_R5: assert (word == 13'b00_0_00_0_0_0_0_00_01);
      if (opcode == OPW'(3))
        assert_jsave_R6: assert (word == 13'b10_0_10_1_0_0_0_00_01);
      if (opcode == OPW'(0) && funct == FNW'(1))
        assert_ldx_R7: assert (word == 13'b01_0_01_1_1_0_0_00_00);
      if (opcode == OPW'(63))
        assert_ijmp_R8: assert (word == 13'b00_1_00_0_1_0_0_00_10);
      if (!(opcode inside {OPW'(0), OPW'(2), OPW'(3), OPW'(4), OPW'(35), OPW'(43), OPW'(63)}))
        assert_unknown_zero_R10: assert (word == 13'b0);
      assert_mem_excl_R11: assert (!(dmem_re && dmem_we) && !(rf_we && dmem_we));
    end
  end
endmodule

bind main_ctrl_dec main_ctrl_dec_chk #(.OPW(OPW), .FNW(FNW)) i_chk (.*);

// File: tb/test_main_ctrl_dec.sv
module test_main_ctrl_dec;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [5:0] opcode, funct;
  logic [1:0] dst_sel, wb_sel, alu_mode, pc_jsel;
  logic alu_b_imm, rf_we, dmem_re, dmem_we, br_eq;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  main_ctrl_dec i_main_ctrl_dec (
    .opcode(opcode), .funct(funct), .dst_sel(dst_sel), .alu_b_imm(alu_b_imm),
    .wb_sel(wb_sel), .rf_we(rf_we), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .br_eq(br_eq), .alu_mode(alu_mode), .pc_jsel(pc_jsel)
  );

  // {dst_sel, alu_b_imm, wb_sel, rf_we, dmem_re, dmem_we, br_eq, alu_mode, pc_jsel}
  function automatic logic [12:0] pack(int dst, int imm, int wb, int we, int re, int mw,
                                       int br, int am, int pj);
    return {dst[1:0], imm[0], wb[1:0], we[0], re[0], mw[0], br[0], am[1:0], pj[1:0]};
  endfunction

  function automatic logic [12:0] expect_word(int op, int fn);
    case (op)
      0:  return (fn == 1) ? pack(1,0,1,1,1,0,0,0,0) : pack(1,0,0,1,0,0,0,2,0);
      35: return pack(0,1,1,1,1,0,0,0,0);
      43: return pack(0,1,0,0,0,1,0,0,0);
      4:  return pack(0,0,0,0,0,0,1,1,0);
      2:  return pack(0,0,0,0,0,0,0,0,1);
      3:  return pack(2,0,2,1,0,0,0,0,1);
      63: return pack(0,1,0,0,1,0,0,0,2);
      default: return 13'b0;
    endcase
  endfunction

  function automatic string tag(int op, int fn);
    case (op)
      0:  return (fn == 1) ? "R7" : "R1";
      35: return (fn != 0) ? "R9/R2" : "R2";
      43: return (fn != 0) ? "R9/R3" : "R3";
      4:  return (fn != 0) ? "R9/R4" : "R4";
      2:  return (fn != 0) ? "R9/R5" : "R5";
      3:  return (fn != 0) ? "R9/R6" : "R6";
      63: return (fn != 0) ? "R9/R8" : "R8";
      default: return (fn != 0) ? "R9/R10" : "R10";
    endcase
  endfunction

  initial begin
    logic [12:0] got, exp;
    opcode = '0;
    funct  = '0;
    @(negedge clk);
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        opcode = op[5:0];
        funct  = fn[5:0];
        #1;
        got = {dst_sel, alu_b_imm, wb_sel, rf_we, dmem_re, dmem_we, br_eq, alu_mode, pc_jsel};
        exp = expect_word(op, fn);
        n_checks++;
        if (got !== exp) begin
          n_fail++;
          $display("FAIL %s op=%0d fn=%0d got=%b exp=%b", tag(op, fn), op, fn, got, exp);
        end
        n_checks++;
        if ((dmem_re && dmem_we) || (rf_we && dmem_we)) begin
          n_fail++;
          $display("FAIL R11 op=%0d fn=%0d got re=%b we=%b rf=%b exp exclusive",
                   op, fn, dmem_re, dmem_we, rf_we);
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule